// File: doc/BRIEF.md
# Hybrid Iterative Decode Sequencer

This block is the control state machine for a two-code decoding flow. Soft values go first to an outer parity-check decoder. If that decoder fails to converge, they go to an inner decoder that works on a row/column single-parity-check array. Two retry passes of the outer decoder follow. In each retry pass, an external LLR modifier rewrites selected values from the inner decoder's output before they re-initialise the outer decoder. The first retry forces confident bits to a fixed large magnitude. The second retry reverses the sign of weak bits.

The sequencer never handles soft data itself. It issues single-cycle start commands, each with an iteration limit, and it waits for the matching completion pulses. It selects the soft-value route through the interleaver, the de-interleaver and the modifier. When a frame ends, it reports success or failure and the stage that produced the result. The outer limit resets to 40 and the inner limit resets to 5. Both limits can be written while no frame is in flight.

Top module: `hybrid_decode_seq`

## Requirements
- R1: After reset the sequencer is idle. All start pulses and `done` are low, `final_ok` is 0, `final_stage` is 0, `llr_route` is 0, `outer_iters` is 40 and `inner_iters` is 5.
- R2: A `frame_start` sampled while idle produces an `outer_start` pulse of one cycle in the next cycle. During that pulse `llr_route` is 0, which routes channel values to the outer decoder.
- R3: If the first outer pass ends with `outer_valid`=1, `done` pulses in the cycle after `outer_done`, with `final_ok`=1 and `final_stage`=1.
- R4: If the first outer pass ends without a valid codeword, `inner_start` pulses in the cycle after `outer_done`. From then on `llr_route` is 1, which routes outer values through the interleaver to the inner decoder, and `inner_iters` carries the inner limit.
- R5: In the cycle after `inner_done`, `mod_start` pulses with `mod_mode`=1 (pin) and `llr_route`=2, which routes inner values through the de-interleaver and the modifier to the outer decoder. In the cycle after `mod_done`, `outer_start` pulses.
- R6: If the pin retry pass ends with `outer_valid`=1, `done` pulses with `final_ok`=1 and `final_stage`=3. A valid codeword takes precedence over `outer_trapped`.
- R7: If the pin retry ends without a valid codeword and with `outer_trapped`=1, `mod_start` pulses with `mod_mode`=2 (flip) and an outer pass follows. The frame then ends with `final_stage`=4, and `final_ok` takes the value of `outer_valid` from that pass.
- R8: If the pin retry ends with neither `outer_valid` nor `outer_trapped`, the frame ends with `final_ok`=0 and `final_stage`=3.
- R9: `done` lasts exactly one cycle. `final_ok` and `final_stage` hold their values until the next accepted `frame_start`, which clears both to 0.
- R10: `frame_start` has no effect while a frame is in flight. It is accepted in the idle state and after a frame has finished.
- R11: A `cfg_wr` pulse loads `cfg_outer_iters` and `cfg_inner_iters` into the limits only while no frame is in flight. While a frame is in flight, `cfg_wr` leaves `outer_iters` and `inner_iters` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Request to decode a new frame |
| cfg_wr | input | 1 | Write strobe for the iteration limits |
| cfg_outer_iters | input | ITW | New outer iteration limit |
| cfg_inner_iters | input | ITW | New inner iteration limit |
| outer_start | output | 1 | Start pulse for the outer decoder |
| outer_iters | output | ITW | Outer iteration limit |
| outer_done | input | 1 | Outer pass finished |
| outer_valid | input | 1 | Outer result is a valid codeword (qualified by outer_done) |
| outer_trapped | input | 1 | Outer decoder ended trapped (qualified by outer_done) |
| inner_start | output | 1 | Start pulse for the array decoder |
| inner_iters | output | ITW | Inner iteration limit |
| inner_done | input | 1 | Array decoder pass finished |
| mod_start | output | 1 | Start pulse for the LLR modifier |
| mod_mode | output | 2 | Modifier action: 0 pass, 1 pin, 2 flip |
| mod_done | input | 1 | Modifier finished |
| llr_route | output | 2 | Soft-value route: 0 channel, 1 to inner, 2 inner to outer via modifier |
| done | output | 1 | One-cycle end-of-frame pulse |
| final_ok | output | 1 | Frame decoded successfully |
| final_stage | output | 3 | Stage of the result: 1 first outer, 3 pin retry, 4 flip retry |

## Verification
A table of frames exercises every escalation path through the stages:
- Success on the first pass shows that the sequencer stops early.
- Success on the pin retry, with and without the trapped flag also raised, shows that a valid result takes precedence.
- A failure without the trapped flag after pinning shows that the flip stage is skipped.
- Success and failure after flipping show that the result is taken from the last pass.

Frames run back to back, which tests restart from both finished states. Directed tests check the values after reset. They also pulse `frame_start` and configuration writes during a busy phase, confirm at the ports that neither has any effect, and confirm that a write while idle does take effect.

// File: rtl/hybrid_decode_seq.sv
module hybrid_decode_seq #(
  parameter int ITW       = 8,
  parameter int OUTER_DEF = 40,
  parameter int INNER_DEF = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_start,
  input  logic           cfg_wr,
  input  logic [ITW-1:0] cfg_outer_iters,
  input  logic [ITW-1:0] cfg_inner_iters,
  output logic           outer_start,
  output logic [ITW-1:0] outer_iters,
  input  logic           outer_done,
  input  logic           outer_valid,
  input  logic           outer_trapped,
  output logic           inner_start,
  output logic [ITW-1:0] inner_iters,
  input  logic           inner_done,
  output logic           mod_start,
  output logic [1:0]     mod_mode,
  input  logic           mod_done,
  output logic [1:0]     llr_route,
  output logic           done,
  output logic           final_ok,
  output logic [2:0]     final_stage
);

  localparam logic [ITW-1:0] OUTER_RST = ITW'(OUTER_DEF);
  localparam logic [ITW-1:0] INNER_RST = ITW'(INNER_DEF);

  typedef enum logic [2:0] {
    S_IDLE, S_OUTER1, S_INNER, S_PIN, S_FLIP, S_OK, S_FAIL
  } st_t;

  st_t  state;
  logic sub;
  logic accept;

  assign accept    = (state == S_IDLE) || (state == S_OK) || (state == S_FAIL);
  assign llr_route = (state == S_INNER) ? 2'd1 :
                     (state == S_PIN || state == S_FLIP) ? 2'd2 : 2'd0;
  assign mod_mode  = (state == S_PIN) ? 2'd1 : (state == S_FLIP) ? 2'd2 : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      sub         <= 1'b0;
      outer_start <= 1'b0;
      inner_start <= 1'b0;
      mod_start   <= 1'b0;
      done        <= 1'b0;
      final_ok    <= 1'b0;
      final_stage <= 3'd0;
      outer_iters <= OUTER_RST;
      inner_iters <= INNER_RST;
    end else begin
      outer_start <= 1'b0;
      inner_start <= 1'b0;
      mod_start   <= 1'b0;
      done        <= 1'b0;
      if (cfg_wr && accept) begin
        outer_iters <= cfg_outer_iters;
        inner_iters <= cfg_inner_iters;
      end
      case (state)
        S_IDLE, S_OK, S_FAIL: begin
          if (frame_start) begin
            state       <= S_OUTER1;
            outer_start <= 1'b1;
            final_ok    <= 1'b0;
            final_stage <= 3'd0;
          end
        end
        S_OUTER1: begin
          if (outer_done) begin
            if (outer_valid) begin
              state       <= S_OK;
              done        <= 1'b1;
              final_ok    <= 1'b1;
              final_stage <= 3'd1;
            end else begin
              state       <= S_INNER;
              inner_start <= 1'b1;
            end
          end
        end
        S_INNER: begin
          if (inner_done) begin
            state     <= S_PIN;
            sub       <= 1'b0;
            mod_start <= 1'b1;
          end
        end
        S_PIN, S_FLIP: begin
          if (!sub && mod_done) begin
            sub         <= 1'b1;
            outer_start <= 1'b1;
          end else if (sub && outer_done) begin
            if (outer_valid) begin
              state       <= S_OK;
              done        <= 1'b1;
              final_ok    <= 1'b1;
              final_stage <= (state == S_PIN) ? 3'd3 : 3'd4;
            end else if (state == S_PIN && outer_trapped) begin
              state     <= S_FLIP;
              sub       <= 1'b0;
              mod_start <= 1'b1;
            end else begin
              state       <= S_FAIL;
              done        <= 1'b1;
              final_stage <= (state == S_PIN) ? 3'd3 : 3'd4;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hybrid_decode_seq_chk.sv
module hybrid_decode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       frame_start,
  input logic       outer_start,
  input logic       outer_done,
  input logic       outer_valid,
  input logic       outer_trapped,
  input logic       inner_start,
  input logic       inner_done,
  input logic       mod_start,
  input logic [1:0] mod_mode,
  input logic [1:0] llr_route,
  input logic       done,
  input logic       final_ok,
  input logic [2:0] final_stage
);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && frame_start) |=> (outer_start && llr_route == 2'd0));

  p_first_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && outer_done && outer_valid) |=> (done && final_ok && final_stage == 3'd1));

  p_inner_after_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inner_start |-> $past(outer_done && !outer_valid));

  p_pin_after_inner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_start && mod_mode == 2'd1) |-> $past(inner_done));

  p_flip_after_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_start && mod_mode == 2'd2) |-> $past(outer_done && outer_trapped && !outer_valid));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == 3'd1 || st == 3'd2) && frame_start) |=> !outer_start);

  p_one_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({outer_start, inner_start, mod_start}));

endmodule

bind hybrid_decode_seq hybrid_decode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(state), .frame_start(frame_start),
  .outer_start(outer_start), .outer_done(outer_done), .outer_valid(outer_valid),
  .outer_trapped(outer_trapped), .inner_start(inner_start), .inner_done(inner_done),
  .mod_start(mod_start), .mod_mode(mod_mode), .llr_route(llr_route),
  .done(done), .final_ok(final_ok), .final_stage(final_stage)
);

// File: tb/tb_hybrid_decode_seq.sv
`timescale 1ns/1ps
module tb_hybrid_decode_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0, cfg_wr = 1'b0;
  logic [7:0] cfg_outer_iters = 8'd0, cfg_inner_iters = 8'd0;
  logic       outer_start, inner_start, mod_start, done, final_ok;
  logic [7:0] outer_iters, inner_iters;
  logic       outer_done = 1'b0, outer_valid = 1'b0, outer_trapped = 1'b0;
  logic       inner_done = 1'b0, mod_done = 1'b0;
  logic [1:0] mod_mode, llr_route;
  logic [2:0] final_stage;
  int checks = 0, errors = 0;
  int exp_o = 40, exp_i = 5;

  always #5 clk = ~clk;

  hybrid_decode_seq dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_wr(cfg_wr),
    .cfg_outer_iters(cfg_outer_iters), .cfg_inner_iters(cfg_inner_iters),
    .outer_start(outer_start), .outer_iters(outer_iters), .outer_done(outer_done),
    .outer_valid(outer_valid), .outer_trapped(outer_trapped), .inner_start(inner_start),
    .inner_iters(inner_iters), .inner_done(inner_done), .mod_start(mod_start),
    .mod_mode(mod_mode), .mod_done(mod_done), .llr_route(llr_route), .done(done),
    .final_ok(final_ok), .final_stage(final_stage)
  );

  // {first_valid, pin_valid, pin_trapped, flip_valid, exp_ok, exp_stage[2:0]}
  localparam logic [7:0] VEC [7] = '{
    8'b1000_1001, 8'b0100_1011, 8'b0011_1100, 8'b0010_0100,
    8'b0000_0011, 8'b0110_1011, 8'b1000_1001
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_outer(input bit v, input bit t);
    outer_done = 1'b1; outer_valid = v; outer_trapped = t;
    @(negedge clk);
    outer_done = 1'b0; outer_valid = 1'b0; outer_trapped = 1'b0;
  endtask

  task automatic pulse_inner();
    inner_done = 1'b1; @(negedge clk); inner_done = 1'b0;
  endtask

  task automatic pulse_mod();
    mod_done = 1'b1; @(negedge clk); mod_done = 1'b0;
  endtask

  task automatic end_check(input bit eok, input int estage, input string req);
    chk(done == 1'b1, {req, " done"}, done, 1);
    chk(final_ok == eok, {req, " ok"}, final_ok, eok);
    chk(final_stage == 3'(estage), {req, " stage"}, final_stage, estage);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    chk(final_ok == eok && final_stage == 3'(estage), "R9 result held", final_stage, estage);
  endtask

  task automatic run_frame(input logic [7:0] v, input bit poke);
    frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
    chk(outer_start == 1'b1 && llr_route == 2'd0, "R2 outer start", outer_start, 1);
    chk(final_ok == 1'b0 && final_stage == 3'd0, "R9 cleared on start", final_stage, 0);
    chk(outer_iters == 8'(exp_o), "R2 outer limit", outer_iters, exp_o);
    @(negedge clk);
    chk(outer_start == 1'b0, "R2 start one cycle", outer_start, 0);
    if (poke) begin
      frame_start = 1'b1; cfg_wr = 1'b1; cfg_outer_iters = 8'd99; cfg_inner_iters = 8'd77;
      @(negedge clk);
      frame_start = 1'b0; cfg_wr = 1'b0;
      chk(outer_start == 1'b0, "R10 busy start ignored", outer_start, 0);
      chk(outer_iters == 8'(exp_o) && inner_iters == 8'(exp_i), "R11 busy cfg ignored",
          outer_iters, exp_o);
    end
    wait_n(2);
    pulse_outer(v[7], !v[7]);
    if (v[7]) begin end_check(1'b1, 1, "R3"); return; end
    chk(inner_start == 1'b1 && llr_route == 2'd1, "R4 inner start", inner_start, 1);
    chk(inner_iters == 8'(exp_i), "R4 inner limit", inner_iters, exp_i);
    wait_n(2);
    pulse_inner();
    chk(mod_start == 1'b1 && mod_mode == 2'd1 && llr_route == 2'd2, "R5 pin modify",
        mod_mode, 1);
    wait_n(2);
    pulse_mod();
    chk(outer_start == 1'b1 && llr_route == 2'd2, "R5 pin outer start", outer_start, 1);
    wait_n(2);
    pulse_outer(v[6], v[5]);
    if (v[6]) begin end_check(1'b1, 3, "R6"); return; end
    if (!v[5]) begin end_check(1'b0, 3, "R8"); return; end
    chk(mod_start == 1'b1 && mod_mode == 2'd2, "R7 flip modify", mod_mode, 2);
    wait_n(1);
    pulse_mod();
    chk(outer_start == 1'b1, "R7 flip outer start", outer_start, 1);
    wait_n(1);
    pulse_outer(v[4], 1'b1);
    end_check(v[4], 4, "R7");
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!outer_start && !inner_start && !mod_start && !done, "R1 idle outputs", done, 0);
    chk(final_ok == 1'b0 && final_stage == 3'd0 && llr_route == 2'd0, "R1 status", final_stage, 0);
    chk(outer_iters == 8'd40 && inner_iters == 8'd5, "R1 limits", outer_iters, 40);
    for (int n = 0; n < 7; n++) run_frame(VEC[n], n == 2);
    cfg_wr = 1'b1; cfg_outer_iters = 8'd12; cfg_inner_iters = 8'd3;
    @(negedge clk); cfg_wr = 1'b0;
    exp_o = 12; exp_i = 3;
    chk(outer_iters == 8'd12 && inner_iters == 8'd3, "R11 idle cfg write", outer_iters, 12);
    run_frame(8'b0011_1100, 1'b1);
    wait_n(3);
    chk(!outer_start && !done, "R10 done state quiet", outer_start, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule